// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is a cycle-accurate synchronous model of the command front end and write state machine of a 16-bit NOR flash bank. A host drives a simple bus: a bank select, a write strobe, a read strobe, an address and a data word. Array changes happen only through multi-cycle unlock sequences. Those sequences cover word program, sector erase, block erase and whole-chip erase, plus entry to and exit from an identification mode. Any other write pattern leaves the array untouched.

A recognised program or erase starts an internal busy phase. Its length in clocks is set by one parameter per operation class. During that phase every command write is ignored. Reads return status bits: a polarity bit on bit 7 and a bit on bit 6 that alternates on each read. When the phase ends, the array word is updated and reads return real data again. The storage is a small register array, sized by parameters, so that results can be observed in simulation.

A write bus cycle is the run of clocks in which `bank_sel` and `wr_stb` are both high. The address is taken in the first clock of that run. The data is the value present in the last clock of the run. The command acts in the first clock after the run ends. A read is any clock with `bank_sel` and `rd_stb` high, and `rdata` shows the result from the next clock on.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset every array word reads 0xFFFF, identification mode is off, and no operation is busy.
- R2: Writing 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, then a data word to a target address programs that word. Reads return the new value once the busy phase of T_PROG clocks has ended.
- R3: Programming can only clear bits. The stored word becomes the old word AND the written data.
- R4: While busy, a read returns a status word in which only bits 7 and 6 may be set. Bit 7 is the inverse of bit 7 of the word being programmed, and it is 0 during any erase.
- R5: Bit 6 of the status word inverts on every read made while busy. The busy phase lasts exactly the configured number of clocks, starting on the clock after the final write. The first read after it ends returns array data.
- R6: Sector erase consists of the five unlock writes (0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55) followed by 0x30 at any address in the sector. It sets to 0xFFFF every word whose address bits from SECTOR_LSB upward match that address, and no other word.
- R7: The same five unlock writes followed by 0x50 erase the block of words whose address bits from BLOCK_LSB upward match the final address.
- R8: The five unlock writes followed by 0x10 at 0x5555 erase every word. The same code at any other address aborts the sequence without erasing.
- R9: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x90 enter identification mode. In that mode a read at word address 0 returns 0x00BF and a read at word address 1 returns DEVICE_CODE.
- R10: A single write of 0xF0 at any address leaves identification mode and returns to array reads. So does the three-write form ending in 0x5555/0xF0.
- R11: Any write that does not match the next expected step of a sequence abandons the sequence. A later data write then has no effect on the array.
- R12: Command addresses are compared on bits 14 to 0 only, so bit 15 and above are ignored. Command codes are compared on data bits 7 to 0 only.
- R13: While busy, every write is ignored, including identification entry and exit. The operation in progress keeps its address, data and kind until it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bank_sel | input | 1 | Selects the bank; strobes count only while it is high |
| wr_stb | input | 1 | Write strobe; one bus write per high run |
| rd_stb | input | 1 | Read strobe; one read per clock it is high |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data or command code |
| rdata | output | 16 | Registered read result: array word, ID code or status |

## Verification
Two events can meet in the same clock: a status read, and the end of the busy phase with its array commit. The bench provokes this by holding the read strobe high without a gap from the clock after a program command is accepted. It then expects exactly T_PROG status words, with bit 6 alternating, followed at once by the new data word. A second overlap comes from issuing an identification entry while a chip erase is still running. It is judged at the read port after completion: address 0 must return erased array data and not the manufacturer code.

// File: rtl/flash_cmd_pkg.sv
// Shared types and constants for the flash command interpreter.
// Assumes 16-bit data and command codes compared on the low byte.
package flash_cmd_pkg;
    localparam int DW = 16;

    localparam logic [14:0] UNLOCK_ADDR_A = 15'h5555;
    localparam logic [14:0] UNLOCK_ADDR_B = 15'h2AAA;

    localparam logic [7:0] CODE_KEY1   = 8'hAA;
    localparam logic [7:0] CODE_KEY2   = 8'h55;
    localparam logic [7:0] CODE_PROG   = 8'hA0;
    localparam logic [7:0] CODE_ERASE  = 8'h80;
    localparam logic [7:0] CODE_IDENT  = 8'h90;
    localparam logic [7:0] CODE_LEAVE  = 8'hF0;
    localparam logic [7:0] CODE_SECTOR = 8'h30;
    localparam logic [7:0] CODE_BLOCK  = 8'h50;
    localparam logic [7:0] CODE_CHIP   = 8'h10;

    localparam logic [DW-1:0] MAKER_CODE = 16'h00BF;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_BLOCK = 2'd2,
        OP_CHIP  = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_K1   = 3'd1,
        SQ_K2   = 3'd2,
        SQ_PGM  = 3'd3,
        SQ_E1   = 3'd4,
        SQ_E2   = 3'd5,
        SQ_E3   = 3'd6
    } seq_state_e;
endpackage

// File: rtl/fcmd_bus_capture.sv
// Turns the strobe-level write bus into one event per bus write.
// The address is taken on the first clock of a write run. The data follows
// the bus while the strobe is high, so the last value is kept. wr_end pulses
// on the first clock after the run ends.
module fcmd_bus_capture
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_sel,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic              wr_end,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DW-1:0]     cmd_data
);
    logic wr_cur;
    logic wr_q;

    assign wr_cur = bank_sel & wr_stb;
    assign wr_end = wr_q & ~wr_cur;

    // Track the strobe and latch address at assertion, data while asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            wr_q <= wr_cur;
            if (wr_cur && !wr_q) cmd_addr <= addr;
            if (wr_cur)          cmd_data <= wdata;
        end
    end
endmodule

// File: rtl/fcmd_sequencer.sv
// Unlock-sequence recogniser. It consumes one completed bus write at a time
// and tracks progress through the program, erase and identification
// sequences. It raises op_start for one clock when a program or erase is
// fully keyed. Writes are ignored while busy_i is high.
module fcmd_sequencer
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_end,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DW-1:0]     cmd_data,
    output logic              op_start,
    output op_kind_e          op_kind,
    output logic              id_mode
);
    seq_state_e st_q, st_d;
    logic       id_d;
    logic       at_a, at_b;
    logic [7:0] code;
    logic       unused_hi;

    assign at_a      = (cmd_addr[14:0] == UNLOCK_ADDR_A);
    assign at_b      = (cmd_addr[14:0] == UNLOCK_ADDR_B);
    assign code      = cmd_data[7:0];
    assign unused_hi = ^{cmd_addr[ADDR_W-1:15], cmd_data[DW-1:8]};

    // Next-state decode for one completed write; any mismatch returns to idle.
    always_comb begin
        st_d     = st_q;
        id_d     = id_mode;
        op_start = 1'b0;
        op_kind  = OP_PROG;
        if (wr_end && !busy_i) begin
            st_d = SQ_IDLE;
            if (st_q == SQ_PGM) begin
                op_start = 1'b1;
                op_kind  = OP_PROG;
            end else if (code == CODE_LEAVE) begin
                id_d = 1'b0;
            end else begin
                case (st_q)
                    SQ_IDLE: if (at_a && code == CODE_KEY1) st_d = SQ_K1;
                    SQ_K1:   if (at_b && code == CODE_KEY2) st_d = SQ_K2;
                    SQ_K2: begin
                        if (at_a && code == CODE_PROG)  st_d = SQ_PGM;
                        if (at_a && code == CODE_ERASE) st_d = SQ_E1;
                        if (at_a && code == CODE_IDENT) id_d = 1'b1;
                    end
                    SQ_E1:   if (at_a && code == CODE_KEY1) st_d = SQ_E2;
                    SQ_E2:   if (at_b && code == CODE_KEY2) st_d = SQ_E3;
                    SQ_E3: begin
                        if (code == CODE_SECTOR) begin
                            op_start = 1'b1;
                            op_kind  = OP_SECT;
                        end else if (code == CODE_BLOCK) begin
                            op_start = 1'b1;
                            op_kind  = OP_BLOCK;
                        end else if (code == CODE_CHIP && at_a) begin
                            op_start = 1'b1;
                            op_kind  = OP_CHIP;
                        end
                    end
                    default: st_d = SQ_IDLE;
                endcase
            end
        end
    end

    // Sequence state and identification-mode flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            id_mode <= 1'b0;
        end else begin
            st_q    <= st_d;
            id_mode <= id_d;
        end
    end

    // A running operation must find the sequencer at rest (R13).
    assert_idle_while_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (st_q == SQ_IDLE));
endmodule

// File: rtl/fcmd_write_engine.sv
// Internal write state machine. It holds the accepted operation and counts
// its busy phase, which lasts exactly the per-kind number of clocks. done
// marks the last busy clock, in which the array commits.
// Assumes every duration parameter is at least 1.
module fcmd_write_engine
    import flash_cmd_pkg::*;
#(
    parameter int ARR_W        = 8,
    parameter int T_PROG       = 8,
    parameter int T_BLK_ERASE  = 20,
    parameter int T_CHIP_ERASE = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  op_kind_e         op_kind_i,
    input  logic [ARR_W-1:0] op_addr_i,
    input  logic [DW-1:0]    op_data_i,
    output logic             busy,
    output logic             done,
    output op_kind_e         op_kind_q,
    output logic [ARR_W-1:0] op_addr_q,
    output logic [DW-1:0]    op_data_q
);
    localparam int T_MAX1 = (T_PROG > T_BLK_ERASE) ? T_PROG : T_BLK_ERASE;
    localparam int T_MAX  = (T_MAX1 > T_CHIP_ERASE) ? T_MAX1 : T_CHIP_ERASE;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Select the remaining-clock count for the requested operation.
    always_comb begin
        case (op_kind_i)
            OP_PROG:  load_val = CNT_W'(T_PROG - 1);
            OP_CHIP:  load_val = CNT_W'(T_CHIP_ERASE - 1);
            default:  load_val = CNT_W'(T_BLK_ERASE - 1);
        endcase
    end

    assign done = busy && (cnt_q == '0);

    // Accept an operation when idle, then count down to its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt_q     <= '0;
            op_kind_q <= OP_PROG;
            op_addr_q <= '0;
            op_data_q <= '0;
        end else if (busy) begin
            if (cnt_q == '0) busy  <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end else if (op_start) begin
            busy      <= 1'b1;
            cnt_q     <= load_val;
            op_kind_q <= op_kind_i;
            op_addr_q <= op_addr_i;
            op_data_q <= op_data_i;
        end
    end

    // Busy may only end once the count is spent (R5).
    assert_busy_ends_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt_q) == '0));

    // The operation in flight is frozen until it completes (R13).
    assert_op_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(op_addr_q) && $stable(op_data_q) && $stable(op_kind_q)));
endmodule

// File: rtl/fcmd_array.sv
// Register-array stand-in for the flash cells. A program commit ANDs the data
// into one word. An erase commit sets to ones every word chosen by the
// sector, block or chip match. The read port is combinational.
// Assumes SECTOR_LSB and BLOCK_LSB are below ARR_W.
module fcmd_array
    import flash_cmd_pkg::*;
#(
    parameter int ARR_W      = 8,
    parameter int SECTOR_LSB = 4,
    parameter int BLOCK_LSB  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  op_kind_e         op_kind,
    input  logic [ARR_W-1:0] op_addr,
    input  logic [DW-1:0]    op_data,
    input  logic [ARR_W-1:0] rd_addr,
    output logic [DW-1:0]    rd_word
);
    localparam int DEPTH = 1 << ARR_W;

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] wipe;

    // Per-word erase selection from the latched operation address.
    for (genvar g = 0; g < DEPTH; g++) begin : g_wipe
        localparam logic [ARR_W-1:0] IDX = ARR_W'(g);
        assign wipe[g] = (op_kind == OP_CHIP)
            || (op_kind == OP_SECT  && IDX[ARR_W-1:SECTOR_LSB] == op_addr[ARR_W-1:SECTOR_LSB])
            || (op_kind == OP_BLOCK && IDX[ARR_W-1:BLOCK_LSB]  == op_addr[ARR_W-1:BLOCK_LSB]);
    end

    // Cell update: erased at reset, cleared bits on program, ones on erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            if (op_kind == OP_PROG) begin
                mem[op_addr] <= mem[op_addr] & op_data;
            end else begin
                for (int i = 0; i < DEPTH; i++) if (wipe[i]) mem[i] <= '1;
            end
        end
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/flash_cmd_engine.sv
// Top of the flash command interpreter. It joins bus capture, the unlock
// sequencer, the write engine and the cell array. It also owns the registered
// read path, which returns status while busy, ID codes in identification
// mode, and array data otherwise.
module flash_cmd_engine
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W       = 18,
    parameter int          ARR_W        = 8,
    parameter int          SECTOR_LSB   = 4,
    parameter int          BLOCK_LSB    = 6,
    parameter int          T_PROG       = 8,
    parameter int          T_BLK_ERASE  = 20,
    parameter int          T_CHIP_ERASE = 40,
    parameter logic [15:0] DEVICE_CODE  = 16'h2789
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_sel,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);
    logic              wr_end;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DW-1:0]     cmd_data;
    logic              op_start, id_mode, busy, done;
    op_kind_e          seq_kind, run_kind;
    logic [ARR_W-1:0]  run_addr;
    logic [DW-1:0]     run_data, rd_word;
    logic              rd_fire, tog_q, poll_bit;

    fcmd_bus_capture #(.ADDR_W(ADDR_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata), .wr_end(wr_end),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data));

    fcmd_sequencer #(.ADDR_W(ADDR_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .busy_i(busy),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .op_start(op_start), .op_kind(seq_kind), .id_mode(id_mode));

    fcmd_write_engine #(.ARR_W(ARR_W), .T_PROG(T_PROG),
        .T_BLK_ERASE(T_BLK_ERASE), .T_CHIP_ERASE(T_CHIP_ERASE)) eng_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind_i(seq_kind),
        .op_addr_i(cmd_addr[ARR_W-1:0]), .op_data_i(cmd_data),
        .busy(busy), .done(done), .op_kind_q(run_kind),
        .op_addr_q(run_addr), .op_data_q(run_data));

    fcmd_array #(.ARR_W(ARR_W), .SECTOR_LSB(SECTOR_LSB), .BLOCK_LSB(BLOCK_LSB)) arr_i (
        .clk(clk), .rst_n(rst_n), .commit(done), .op_kind(run_kind),
        .op_addr(run_addr), .op_data(run_data),
        .rd_addr(addr[ARR_W-1:0]), .rd_word(rd_word));

    assign rd_fire  = bank_sel & rd_stb;
    assign poll_bit = (run_kind == OP_PROG) ? ~run_data[7] : 1'b0;

    // Read result register and the alternating bit used while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            tog_q <= 1'b0;
        end else if (rd_fire) begin
            if (busy) begin
                rdata <= {8'h00, poll_bit, tog_q, 6'b0};
                tog_q <= ~tog_q;
            end else if (id_mode && addr[ADDR_W-1:1] == '0) begin
                rdata <= addr[0] ? DEVICE_CODE : MAKER_CODE;
            end else begin
                rdata <= rd_word;
            end
        end
    end

    // Back-to-back busy reads must show opposite bit 6 (R5).
    assert_toggle_alternates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && busy && $past(rd_fire && busy)) |=> (rdata[6] != $past(rdata[6])));

    // Erase status reads never show bit 7 set (R4).
    assert_erase_poll_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && busy && run_kind != OP_PROG) |=> !rdata[7]);
endmodule

// File: tb/flash_cmd_engine_tb_top.sv
// Directed bench for flash_cmd_engine: one task per scenario, each checking
// its own results at the read port.
`timescale 1ns/1ps
module flash_cmd_engine_tb_top;
    localparam int TP = 8;
    localparam int TE = 20;
    localparam int TC = 40;
    localparam logic [15:0] DEV = 16'h2789;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_sel = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [17:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    int          n_checks = 0, n_fail = 0;
    bit          finished = 1'b0;

    flash_cmd_engine #(.ADDR_W(18), .ARR_W(8), .SECTOR_LSB(4), .BLOCK_LSB(6),
        .T_PROG(TP), .T_BLK_ERASE(TE), .T_CHIP_ERASE(TC), .DEVICE_CODE(DEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .addr(addr), .wdata(wdata), .rdata(rdata));

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [17:0] a, input logic [15:0] d);
        @(negedge clk);
        bank_sel = 1'b1; wr_stb = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic bus_rd(input logic [17:0] a, output logic [15:0] d);
        @(negedge clk);
        bank_sel = 1'b1; rd_stb = 1'b1; addr = a;
        @(negedge clk);
        rd_stb = 1'b0;
        d = rdata;
    endtask

    task automatic expect_word(input string req, input logic [17:0] a, input logic [15:0] exp);
        logic [15:0] v;
        bus_rd(a, v);
        check(req, v, exp);
    endtask

    task automatic keys3(input logic [7:0] c);
        bus_wr(18'h05555, 16'h00AA);
        bus_wr(18'h02AAA, 16'h0055);
        bus_wr(18'h05555, {8'h00, c});
    endtask

    task automatic program_word(input logic [17:0] a, input logic [15:0] d);
        keys3(8'hA0);
        bus_wr(a, d);
    endtask

    task automatic erase6(input logic [17:0] a, input logic [7:0] c);
        keys3(8'h80);
        bus_wr(18'h05555, 16'h00AA);
        bus_wr(18'h02AAA, 16'h0055);
        bus_wr(a, {8'h00, c});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        expect_word("R1 reset word 0", 18'h00000, 16'hFFFF);
        expect_word("R1 reset word 0x55", 18'h00055, 16'hFFFF);
    endtask

    task automatic t_program;
        program_word(18'h00010, 16'h1234);
        idle(TP + 3);
        expect_word("R2 programmed word", 18'h00010, 16'h1234);
    endtask

    // Continuous read across the end of a program busy phase.
    task automatic t_program_boundary;
        logic prev6;
        program_word(18'h00020, 16'h5A5A);
        @(negedge clk);
        bank_sel = 1'b1; rd_stb = 1'b1; addr = 18'h00020;
        @(negedge clk);
        check("R4 program status word", rdata & 16'hFFBF, 16'h0080);
        prev6 = rdata[6];
        for (int k = 1; k < TP; k++) begin
            @(negedge clk);
            check("R4 program status word", rdata & 16'hFFBF, 16'h0080);
            check("R5 bit 6 alternates", {15'h0, rdata[6]}, {15'h0, ~prev6});
            prev6 = rdata[6];
        end
        @(negedge clk);
        check("R5 data right after busy", rdata, 16'h5A5A);
        rd_stb = 1'b0;
    endtask

    task automatic t_and;
        program_word(18'h00010, 16'hFF00);
        idle(TP + 3);
        expect_word("R3 program only clears bits", 18'h00010, 16'h1200);
    endtask

    task automatic t_abort;
        bus_wr(18'h05555, 16'h00AA);
        bus_wr(18'h02AAA, 16'h0055);
        bus_wr(18'h05555, 16'h0077);
        bus_wr(18'h00045, 16'h0000);
        idle(TP + 3);
        expect_word("R11 broken sequence no program", 18'h00045, 16'hFFFF);
    endtask

    task automatic t_high_addr;
        bus_wr(18'h0D555, 16'hC3AA);
        bus_wr(18'h0AAAA, 16'h1255);
        bus_wr(18'h0D555, 16'h00A0);
        bus_wr(18'h00045, 16'h0F0F);
        idle(TP + 3);
        expect_word("R12 bit 15 and upper code byte ignored", 18'h00045, 16'h0F0F);
        program_word(18'h00080, 16'h3C3C);
        idle(TP + 3);
        expect_word("R2 second programmed word", 18'h00080, 16'h3C3C);
    endtask

    task automatic t_sector;
        logic [15:0] v;
        erase6(18'h00015, 8'h30);
        bus_rd(18'h00010, v);
        check("R4 erase status bit 7 low", v & 16'hFFBF, 16'h0000);
        idle(TE + 3);
        expect_word("R6 sector word erased", 18'h00010, 16'hFFFF);
        expect_word("R6 other sector kept", 18'h00020, 16'h5A5A);
    endtask

    task automatic t_block;
        erase6(18'h00033, 8'h50);
        idle(TE + 3);
        expect_word("R7 block word erased", 18'h00020, 16'hFFFF);
        expect_word("R7 next block kept", 18'h00045, 16'h0F0F);
        expect_word("R7 far block kept", 18'h00080, 16'h3C3C);
    endtask

    task automatic t_chip_wrong_addr;
        erase6(18'h00100, 8'h10);
        idle(TC + 3);
        expect_word("R8 chip code off 0x5555 aborts", 18'h00045, 16'h0F0F);
    endtask

    task automatic t_busy_ignore;
        erase6(18'h05555, 8'h10);
        keys3(8'h90);
        idle(TC + 3);
        expect_word("R13 ID entry while busy ignored", 18'h00000, 16'hFFFF);
        expect_word("R8 chip erase word 0x45", 18'h00045, 16'hFFFF);
        expect_word("R8 chip erase word 0x80", 18'h00080, 16'hFFFF);
    endtask

    task automatic t_ident;
        keys3(8'h90);
        expect_word("R9 maker code", 18'h00000, 16'h00BF);
        expect_word("R9 device code", 18'h00001, DEV);
        bus_wr(18'h01234, 16'h00F0);
        expect_word("R10 single-write exit", 18'h00000, 16'hFFFF);
        keys3(8'h90);
        expect_word("R9 maker code again", 18'h00000, 16'h00BF);
        keys3(8'hF0);
        expect_word("R10 three-write exit", 18'h00000, 16'hFFFF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_program_boundary();
        t_and();
        t_abort();
        t_high_addr();
        t_sector();
        t_block();
        t_chip_wrong_addr();
        t_busy_ignore();
        t_ident();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule